// File: doc/BRIEF.md
# Shared-temp 16-bit register bridge

This block sits between an 8-bit processor bus and a peripheral that owns several 16-bit values. It serves a free-running counter, which the processor can both read and load, and a parameterised set of compare registers, two by default. It also serves a capture value, which the processor can only read. The bus moves one byte per access. To move a 16-bit value as a single unit, the block keeps one 8-bit holding byte, and every register shares it.

On a write, the processor first writes the upper half, which only loads the holding byte. The lower-half write then delivers the whole word {holding byte, data} to its target in one cycle. On a read of the counter or capture value, the processor reads the lower half first. That read also copies the upper half of the same sample into the holding byte, and the following upper-half read returns that copy. Compare registers live inside the block and are read back directly. The counter and capture values come from the peripheral, and the block forwards counter loads to it as a one-cycle strobe with a 16-bit word.

Top module: `reg_bridge16`

## Requirements
- R1: After reset, the read data output, every compare value and every write strobe are zero.
- R2: The register index is the address with bit 0 removed; address bit 0 set selects the upper half. With the defaults, index 0 is the counter, indices 1 and 2 are compare registers 0 and 1, and index 3 is the capture value, so the addresses are 0 through 7. A write to an upper-half address only loads the shared holding byte. It raises no strobe and changes no compare value.
- R3: A write to address 0 (counter, lower half) raises the counter write strobe for exactly the one cycle after the write. The strobe carries the word {holding byte, written data}.
- R4: A write to the lower-half address of compare register n (address 2 or 4) sets that register to {holding byte, written data} in the cycle after the write. It also pulses that register's strobe bit for one cycle; strobe bit 0 belongs to register 0.
- R5: Read data appears in the cycle after a read and holds until the next read. A read of address 0 returns the counter's lower byte, and a later read of address 1 returns the upper byte of that same sample, even if the counter has changed since.
- R6: A read of address 6 returns the capture value's lower byte, and a later read of address 7 returns the upper byte of that same sample.
- R7: Reads of compare addresses return the register's own bytes, not the holding byte, and leave the holding byte unchanged.
- R8: The holding byte is shared. An upper-half write to one register followed by a lower-half write to another register commits the earlier byte as the second register's upper half, and the first register stays unchanged.
- R9: A write to address 6 (capture, lower half) has no effect: no strobe and no change to any compare value.
- R10: At most one write strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address: register index above bit 0, bit 0 selects the upper half |
| bus_wdata_i | input | BYTE_W | Write data byte |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_rdata_o | output | BYTE_W | Registered read data |
| cnt_val_i | input | 2*BYTE_W | Current counter value from the peripheral |
| cap_val_i | input | 2*BYTE_W | Current capture value from the peripheral |
| cnt_wr_o | output | 1 | Counter load strobe |
| cnt_wdata_o | output | 2*BYTE_W | Counter load word |
| cmp_wr_o | output | NUM_CMP | Per compare register commit strobe |
| cmp_val_o | output | NUM_CMP*2*BYTE_W | Compare register values, register 0 in the low bits |

## Verification
Every result of this block is due exactly one clock after the access that causes it. Read data, holding-byte loads, compare updates and both kinds of strobe all come from a single register stage. For each bus access, the driver records the read data, strobe vector and compare values that must appear at the next falling edge. It also records the counter word whenever a commit is expected. The monitor compares them at that edge and nowhere else. A missing pulse, a pulse one cycle late, or read data that drifts while the bus is idle therefore all show up as a miscompare.

// File: rtl/rb_pkg.sv
package rb_pkg;

   typedef enum logic [1:0] {
      TGT_CNT  = 2'd0,
      TGT_CMP  = 2'd1,
      TGT_CAP  = 2'd2,
      TGT_NONE = 2'd3
   } tgt_e;

   typedef struct packed {
      tgt_e       kind;
      logic       hi;
      logic [7:0] cmp_n;
   } dec_t;

   // Map a register index onto its target: counter first, then compares,
   // then the capture value.
   function automatic dec_t classify(input int unsigned idx,
                                     input logic        hi,
                                     input int unsigned ncmp);
      dec_t d;
      d.hi    = hi;
      d.cmp_n = '0;
      if (idx == 0) begin
         d.kind = TGT_CNT;
      end else if (idx <= ncmp) begin
         d.kind  = TGT_CMP;
         d.cmp_n = 8'(idx - 1);
      end else if (idx == ncmp + 1) begin
         d.kind = TGT_CAP;
      end else begin
         d.kind = TGT_NONE;
      end
      return d;
   endfunction

endpackage

// File: rtl/rb_decode.sv
module rb_decode
   import rb_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int NUM_CMP = 2
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   output logic               wr_hi_o,
   output logic               wr_cnt_lo_o,
   output logic [NUM_CMP-1:0] wr_cmp_lo_o,
   output logic               wr_cap_lo_o,
   output dec_t               dec_o
);

   dec_t dec;

   always_comb begin
      dec         = classify(32'(addr_i[ADDR_W-1:1]), addr_i[0], NUM_CMP);
      wr_hi_o     = wr_i && dec.hi && (dec.kind != TGT_NONE);
      wr_cnt_lo_o = wr_i && !dec.hi && (dec.kind == TGT_CNT);
      wr_cap_lo_o = wr_i && !dec.hi && (dec.kind == TGT_CAP);
      for (int k = 0; k < NUM_CMP; k++) begin
         wr_cmp_lo_o[k] = wr_i && !dec.hi && (dec.kind == TGT_CMP)
                          && (dec.cmp_n == 8'(k));
      end
      dec_o = dec;
   end

endmodule

// File: rtl/rb_temp.sv
module rb_temp #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load_i,
   input  logic [BYTE_W-1:0] wr_byte_i,
   input  logic              rd_load_i,
   input  logic [BYTE_W-1:0] rd_byte_i,
   output logic [BYTE_W-1:0] tmp_o
);

   logic [BYTE_W-1:0] tmp_q;

   // A bus write owns the holding byte over a read latch in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmp_q <= '0;
      end else if (wr_load_i) begin
         tmp_q <= wr_byte_i;
      end else if (rd_load_i) begin
         tmp_q <= rd_byte_i;
      end
   end

   assign tmp_o = tmp_q;

   // R2
   hi_write_loads_tmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load_i |=> tmp_o == $past(wr_byte_i));

   // R7
   tmp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_load_i && !rd_load_i) |=> $stable(tmp_o));

endmodule

// File: rtl/rb_cmp_bank.sv
module rb_cmp_bank #(
   parameter int BYTE_W  = 8,
   parameter int NUM_CMP = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CMP-1:0]            commit_i,
   input  logic [2*BYTE_W-1:0]           word_i,
   output logic [NUM_CMP*2*BYTE_W-1:0]   val_o,
   output logic [NUM_CMP-1:0]            strobe_o
);

   localparam int WORD_W = 2 * BYTE_W;

   for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_ch
      logic [WORD_W-1:0] val_q;
      logic              stb_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            stb_q <= 1'b0;
         end else begin
            stb_q <= commit_i[ch];
            if (commit_i[ch]) begin
               val_q <= word_i;
            end
         end
      end

      assign val_o[ch*WORD_W +: WORD_W] = val_q;
      assign strobe_o[ch]               = stb_q;

      // R4
      cmp_commit_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
         strobe_o[ch] |-> val_o[ch*WORD_W +: WORD_W] == $past(word_i));

      // R2
      cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !commit_i[ch] |=> $stable(val_o[ch*WORD_W +: WORD_W]));
   end

endmodule

// File: rtl/rb_rdsel.sv
module rb_rdsel
   import rb_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int NUM_CMP = 2
) (
   input  dec_t                         dec_i,
   input  logic [BYTE_W-1:0]            tmp_i,
   input  logic [2*BYTE_W-1:0]          cnt_i,
   input  logic [2*BYTE_W-1:0]          cap_i,
   input  logic [NUM_CMP*2*BYTE_W-1:0]  cmp_i,
   output logic [BYTE_W-1:0]            byte_o,
   output logic                         latch_o,
   output logic [BYTE_W-1:0]            latch_byte_o
);

   localparam int WORD_W = 2 * BYTE_W;

   logic [WORD_W-1:0] word;
   logic              live;

   always_comb begin
      word = '0;
      unique case (dec_i.kind)
         TGT_CNT: word = cnt_i;
         TGT_CAP: word = cap_i;
         TGT_CMP: begin
            for (int k = 0; k < NUM_CMP; k++) begin
               if (dec_i.cmp_n == 8'(k)) begin
                  word = cmp_i[k*WORD_W +: WORD_W];
               end
            end
         end
         default: word = '0;
      endcase

      // Live values pass their upper half through the holding byte.
      live         = (dec_i.kind == TGT_CNT) || (dec_i.kind == TGT_CAP);
      latch_o      = live && !dec_i.hi;
      latch_byte_o = word[WORD_W-1:BYTE_W];
      if (live && dec_i.hi) begin
         byte_o = tmp_i;
      end else if (dec_i.hi) begin
         byte_o = word[WORD_W-1:BYTE_W];
      end else begin
         byte_o = word[BYTE_W-1:0];
      end
   end

endmodule

// File: rtl/reg_bridge16.sv
module reg_bridge16
   import rb_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int NUM_CMP = 2,
   parameter int ADDR_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr_i,
   input  logic [BYTE_W-1:0]             bus_wdata_i,
   input  logic                          bus_wr_i,
   input  logic                          bus_rd_i,
   output logic [BYTE_W-1:0]             bus_rdata_o,
   input  logic [2*BYTE_W-1:0]           cnt_val_i,
   input  logic [2*BYTE_W-1:0]           cap_val_i,
   output logic                          cnt_wr_o,
   output logic [2*BYTE_W-1:0]           cnt_wdata_o,
   output logic [NUM_CMP-1:0]            cmp_wr_o,
   output logic [NUM_CMP*2*BYTE_W-1:0]   cmp_val_o
);

   localparam int WORD_W  = 2 * BYTE_W;
   localparam int NUM_REG = NUM_CMP + 2;
   localparam int IDX_W   = ADDR_W - 1;

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be at least 1");
   end
   if (NUM_CMP < 1 || NUM_CMP > 255) begin : g_bad_ncmp
      $error("NUM_CMP must lie in 1..255");
   end
   if (IDX_W < 1 || (1 << IDX_W) < NUM_REG) begin : g_bad_addr
      $error("ADDR_W too narrow for the register count");
   end

   logic               wr_hi, wr_cnt_lo, wr_cap_lo;
   logic [NUM_CMP-1:0] wr_cmp_lo;
   dec_t               dec;
   logic [BYTE_W-1:0]  tmp_q;
   logic [BYTE_W-1:0]  rd_byte, latch_byte;
   logic               latch;
   logic [WORD_W-1:0]  commit_word;

   rb_decode #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_dec (
      .addr_i      (bus_addr_i),
      .wr_i        (bus_wr_i),
      .wr_hi_o     (wr_hi),
      .wr_cnt_lo_o (wr_cnt_lo),
      .wr_cmp_lo_o (wr_cmp_lo),
      .wr_cap_lo_o (wr_cap_lo),
      .dec_o       (dec)
   );

   rb_temp #(.BYTE_W(BYTE_W)) u_tmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_load_i (wr_hi),
      .wr_byte_i (bus_wdata_i),
      .rd_load_i (bus_rd_i && latch),
      .rd_byte_i (latch_byte),
      .tmp_o     (tmp_q)
   );

   assign commit_word = {tmp_q, bus_wdata_i};

   rb_cmp_bank #(.BYTE_W(BYTE_W), .NUM_CMP(NUM_CMP)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (wr_cmp_lo),
      .word_i   (commit_word),
      .val_o    (cmp_val_o),
      .strobe_o (cmp_wr_o)
   );

   rb_rdsel #(.BYTE_W(BYTE_W), .NUM_CMP(NUM_CMP)) u_rd (
      .dec_i        (dec),
      .tmp_i        (tmp_q),
      .cnt_i        (cnt_val_i),
      .cap_i        (cap_val_i),
      .cmp_i        (cmp_val_o),
      .byte_o       (rd_byte),
      .latch_o      (latch),
      .latch_byte_o (latch_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata_o <= '0;
         cnt_wr_o    <= 1'b0;
         cnt_wdata_o <= '0;
      end else begin
         cnt_wr_o <= wr_cnt_lo;
         if (wr_cnt_lo) begin
            cnt_wdata_o <= commit_word;
         end
         if (bus_rd_i) begin
            bus_rdata_o <= rd_byte;
         end
      end
   end

   // R3
   cnt_strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_o |-> ($past(bus_wr_i) && $past(bus_addr_i) == '0));

   // R8
   cnt_word_from_tmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_o |-> cnt_wdata_o[WORD_W-1:BYTE_W] == $past(tmp_q));

   // R10
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cnt_wr_o, cmp_wr_o}));

   // R5
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> $stable(bus_rdata_o));

   // R6
   low_read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && latch && !wr_hi) |=> tmp_q == $past(latch_byte));

   // R9
   cap_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cap_lo |=> (!cnt_wr_o && cmp_wr_o == '0));

endmodule

// File: tb/sim_reg_bridge16.sv
module sim_reg_bridge16;

   localparam int CLK_PERIOD = 10;
   localparam int BW = 8;
   localparam int NC = 2;
   localparam int AW = 3;
   localparam int WW = 2 * BW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic [BW-1:0]     wdata = '0;
   logic              wr = 1'b0;
   logic              rd = 1'b0;
   logic [BW-1:0]     rdata;
   logic [WW-1:0]     cnt_v = '0;
   logic [WW-1:0]     cap_v = '0;
   logic              cnt_wr;
   logic [WW-1:0]     cnt_wdata;
   logic [NC-1:0]     cmp_wr;
   logic [NC*WW-1:0]  cmp_val;

   always #(CLK_PERIOD/2) clk = ~clk;

   reg_bridge16 #(.BYTE_W(BW), .NUM_CMP(NC), .ADDR_W(AW)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_rdata_o (rdata),
      .cnt_val_i   (cnt_v),
      .cap_val_i   (cap_v),
      .cnt_wr_o    (cnt_wr),
      .cnt_wdata_o (cnt_wdata),
      .cmp_wr_o    (cmp_wr),
      .cmp_val_o   (cmp_val)
   );

   typedef struct {
      int          due;
      int          sel;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sbq[$];
   int    cyc   = 0;
   int    n_chk = 0;
   int    n_bad = 0;

   // Reference state derived from the requirements.
   logic [BW-1:0] m_tmp = '0;
   logic [BW-1:0] m_rd  = '0;
   logic [WW-1:0] m_cmp0 = '0;
   logic [WW-1:0] m_cmp1 = '0;
   logic [WW-1:0] m_cntw = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic push(input int sel, input logic [31:0] exp, input string tag);
      item_t it;
      it.due = cyc + 1;
      it.sel = sel;
      it.exp = exp;
      it.tag = tag;
      sbq.push_back(it);
   endtask

   // Strobe vector layout: {counter, compare1, compare0}.
   task automatic expect_all(input logic [2:0] strb, input string tag);
      push(0, 32'(m_rd), tag);
      push(1, 32'(strb), tag);
      push(2, 32'(m_cmp0), tag);
      push(3, 32'(m_cmp1), tag);
      if (strb[2]) push(4, 32'(m_cntw), tag);
   endtask

   task automatic bus_idle(input string tag);
      @(negedge clk);
      wr = 1'b0;
      rd = 1'b0;
      expect_all(3'b000, tag);
   endtask

   task automatic bus_wr(input int a, input logic [BW-1:0] d, input string tag);
      logic [2:0]    strb;
      logic [WW-1:0] w;
      @(negedge clk);
      addr  = AW'(a);
      wdata = d;
      wr    = 1'b1;
      rd    = 1'b0;
      strb  = 3'b000;
      if (a % 2 == 1) begin
         m_tmp = d;
      end else begin
         w = {m_tmp, d};
         case (a / 2)
            0: begin m_cntw = w; strb = 3'b100; end
            1: begin m_cmp0 = w; strb = 3'b001; end
            2: begin m_cmp1 = w; strb = 3'b010; end
            default: strb = 3'b000;
         endcase
      end
      expect_all(strb, tag);
   endtask

   task automatic bus_rd(input int a, input logic [WW-1:0] cnt,
                         input logic [WW-1:0] cap, input string tag);
      logic hi;
      @(negedge clk);
      addr  = AW'(a);
      wr    = 1'b0;
      rd    = 1'b1;
      cnt_v = cnt;
      cap_v = cap;
      hi    = (a % 2 == 1);
      case (a / 2)
         0: if (hi) m_rd = m_tmp; else begin m_rd = cnt[7:0]; m_tmp = cnt[15:8]; end
         1: m_rd = hi ? m_cmp0[15:8] : m_cmp0[7:0];
         2: m_rd = hi ? m_cmp1[15:8] : m_cmp1[7:0];
         default: if (hi) m_rd = m_tmp; else begin m_rd = cap[7:0]; m_tmp = cap[15:8]; end
      endcase
      expect_all(3'b000, tag);
   endtask

   // Monitor: compare each result at the falling edge it is due.
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
         item_t       it;
         logic [31:0] act;
         it = sbq.pop_front();
         case (it.sel)
            0:       act = 32'(rdata);
            1:       act = 32'({cnt_wr, cmp_wr});
            2:       act = 32'(cmp_val[WW-1:0]);
            3:       act = 32'(cmp_val[2*WW-1:WW]);
            default: act = 32'(cnt_wdata);
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s item %0d at cycle %0d: actual %h expected %h",
                     it.tag, it.sel, cyc, act, it.exp);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: everything zero out of reset
      bus_idle("R1");
      bus_idle("R1");

      // R2: upper write alone changes nothing visible
      bus_wr(3, 8'h12, "R2");
      bus_idle("R2");
      // R4: commit compare 0, then compare 1 back to back
      bus_wr(2, 8'h34, "R4");
      bus_wr(5, 8'hAB, "R4");
      bus_wr(4, 8'hCD, "R4");
      bus_idle("R4");

      // R3: counter load
      bus_wr(1, 8'h5A, "R3");
      bus_wr(0, 8'hA5, "R3");
      bus_idle("R3");

      // R8: stale holding byte lands on another register
      bus_wr(3, 8'h77, "R8");
      bus_wr(0, 8'h11, "R8");
      bus_wr(1, 8'h99, "R8");
      bus_wr(4, 8'h22, "R8");
      bus_idle("R8");

      // R9: capture lower write ignored
      bus_wr(6, 8'hEE, "R9");
      bus_idle("R9");

      // R5: counter read sees one sample; idle holds the data
      bus_rd(0, 16'h3C4D, 16'h0000, "R5");
      bus_idle("R5");
      bus_rd(1, 16'hFFEE, 16'h0000, "R5");
      bus_idle("R5");
      bus_idle("R5");

      // R6: capture read sees one sample
      bus_rd(6, 16'h0000, 16'h8001, "R6");
      bus_rd(7, 16'h1234, 16'h0000, "R6");

      // R7: compare reads are direct and leave the holding byte alone
      bus_rd(0, 16'h6502, 16'h0000, "R7");
      bus_rd(2, 16'h0000, 16'h0000, "R7");
      bus_rd(3, 16'h0000, 16'h0000, "R7");
      bus_rd(4, 16'h0000, 16'h0000, "R7");
      bus_rd(5, 16'h0000, 16'h0000, "R7");
      bus_rd(1, 16'hAAAA, 16'h5555, "R7");

      // R10: alternating commits never overlap
      bus_wr(1, 8'h01, "R10");
      bus_wr(0, 8'h02, "R10");
      bus_wr(2, 8'h03, "R10");
      bus_wr(4, 8'h04, "R10");
      bus_wr(0, 8'h05, "R10");
      bus_idle("R10");
      bus_idle("R10");

      repeat (3) @(negedge clk);
      if (sbq.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule